// File: doc/BRIEF.md
# Ring-Oscillator Frequency-to-Temperature Converter

This block turns the edge rate of one free-running ring oscillator into an on-die temperature reading. The oscillator is switched on only during a short measurement window, so it heats itself as little as possible. During that window the block counts the oscillator's rising edges against a fixed number of system-clock cycles. The oscillator is then switched off for a rest interval, and the cycle repeats for as long as `enable` stays high. With the default settings the system clock is 50 MHz, the window is 4000 cycles (80 µs) and the rest is 2750 cycles, so one conversion completes every 135 µs (about 7.4 kHz).

At the end of each window the edge count is converted by a linear calibration with a negative slope, because the oscillator slows as the die warms. The calibration point is 25.00 °C at a count of `F_CAL_COUNT`, and each count below that point adds `K_Q / 2^FRAC` centi-degrees. The defaults assume the oscillator is divided by eight before it reaches the block: about 99.88 MHz at 25 °C, falling by about 2.07 MHz per 10 °C, which gives a count of 999 at 25 °C and about 48.3 centi-degrees per count. The count and the temperature are published together with a one-cycle `done` pulse and are held until the next conversion.

The oscillator input is asynchronous. It passes through a two-flop synchronizer and is edge-detected in the system-clock domain, so the signal arriving at the block must run below half the system clock.

Top module: `ro_temp_conv`

## Requirements
- R1: While `enable` is high, the block alternates between a rest interval of `REST_CYCLES` cycles with `ro_en` low and a measurement window of `GATE_CYCLES` cycles with `ro_en` high. The first rest interval begins on the first rising clock edge at which `enable` is sampled high.
- R2: The published `freq_count` equals the number of window cycles in which `ro_in` was sampled 1 two edges earlier and 0 three edges earlier. This is the rising-edge count after the two-flop synchronizer. The count restarts from zero in every window.
- R3: `freq_count` and `temp_cdeg` change only in the cycle in which `done` is high. At all other times they hold their last values.
- R4: `done` is high for exactly one cycle: the second cycle after the last cycle of a completed window.
- R5: `temp_cdeg` is a two's-complement value in centi-degrees: 2500 + floor(((F_CAL_COUNT − n)·K_Q + 2^(FRAC−1)) / 2^FRAC), where n is the published count. Counts above the calibration point give values below 2500.
- R6: When a rising edge arrives while the counter is all ones, the counter stays at all ones and `overflow` goes high. `overflow` stays high until reset.
- R7: When `enable` is sampled low, `ro_en` is low from the next cycle onward. A window cut short this way produces no `done`, and the published results are left unchanged.
- R8: Reset (`rst_n` low) clears `freq_count`, `temp_cdeg`, `done`, `overflow` and `ro_en` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| enable | input | 1 | Runs back-to-back conversions while high |
| ro_in | input | 1 | Raw oscillator signal, asynchronous to `clk` |
| ro_en | output | 1 | Oscillator run enable, high only during the measurement window |
| freq_count | output | CNT_W | Edge count of the last completed window |
| temp_cdeg | output | TEMP_W | Temperature of the last completed window, signed, in centi-degrees |
| done | output | 1 | One-cycle pulse when new results are published |
| overflow | output | 1 | Sticky flag: the edge counter saturated |

## Verification
The bench builds the block with a 40-cycle window, a 10-cycle rest, a 4-bit counter, a calibration count of 10 and K_Q = 300 with FRAC = 4. These small values let many complete conversions run in a short time. They put counts on both sides of the calibration point, so temperatures both above and below 25 °C appear, and they exercise the rounding of negative products. They also let an oscillator running at half the clock rate push the 4-bit counter past all ones, which triggers saturation and the sticky flag. The oscillator model toggles at several periods between 2 and 8 clock cycles, and one window is cut short by dropping `enable`.

// File: rtl/ro_temp_pkg.sv
package ro_temp_pkg;

  // Conversion sequencer phases
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_REST = 2'd1,
    PH_GATE = 2'd2
  } phase_e;

endpackage

// File: rtl/ro_sync_edge.sv
// Brings the asynchronous oscillator into the clk domain and flags rising edges.
module ro_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ro_in,
  output logic rise
);

  localparam int PIPE_W = STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;
  logic [PIPE_W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[PIPE_W-2:0], ro_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  // Last synchronizer stage is 1, the history stage behind it is 0
  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/ro_gate_ctrl.sv
// Rest / window sequencer. The window drives the oscillator enable.
module ro_gate_ctrl
  import ro_temp_pkg::*;
#(
  parameter int REST_CYCLES = 2750,
  parameter int GATE_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic gate_open,
  output logic win_close
);

  localparam int TMR_MAX = (REST_CYCLES > GATE_CYCLES) ? REST_CYCLES : GATE_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] REST_LAST = TMR_W'(REST_CYCLES - 1);
  localparam logic [TMR_W-1:0] GATE_LAST = TMR_W'(GATE_CYCLES - 1);

  phase_e           ph_q, ph_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;

  always_comb begin
    ph_d      = ph_q;
    tmr_d     = tmr_q;
    win_close = 1'b0;
    unique case (ph_q)
      PH_OFF: begin
        tmr_d = '0;
        if (enable) begin
          ph_d = PH_REST;
        end
      end
      PH_REST: begin
        if (!enable) begin
          ph_d  = PH_OFF;
          tmr_d = '0;
        end else if (tmr_q == REST_LAST) begin
          ph_d  = PH_GATE;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      PH_GATE: begin
        if (!enable) begin
          ph_d  = PH_OFF;
          tmr_d = '0;
        end else if (tmr_q == GATE_LAST) begin
          ph_d      = PH_REST;
          tmr_d     = '0;
          win_close = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: begin
        ph_d  = PH_OFF;
        tmr_d = '0;
      end
    endcase
  end

  assign tmr_en = (tmr_d != tmr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_OFF;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  assign gate_open = (ph_q == PH_GATE);

endmodule

// File: rtl/ro_edge_counter.sv
// Saturating window edge counter with sticky overflow and a result latch.
module ro_edge_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_open,
  input  logic             rise,
  input  logic             win_close,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_count,
  output logic             overflow
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             ovf_q, ovf_d;
  logic             vld_q;
  logic             full;

  assign full = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (!gate_open) begin
      cnt_d = '0;
    end else if (rise) begin
      if (full) begin
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // The closing cycle's own edge is included in the latched result
  always_comb begin
    res_d = win_close ? cnt_d : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      vld_q <= win_close;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (win_close) begin
      res_q <= res_d;
    end
  end

  assign res_valid = vld_q;
  assign res_count = res_q;
  assign overflow  = ovf_q;

endmodule

// File: rtl/ro_temp_calc.sv
// Linear count-to-temperature mapping with round-half-up, registered output.
module ro_temp_calc #(
  parameter int CNT_W       = 12,
  parameter int TEMP_W      = 16,
  parameter int F_CAL_COUNT = 999,
  parameter int T_CAL_CDEG  = 2500,
  parameter int KQ_W        = 16,
  parameter int K_Q         = 12367,
  parameter int FRAC        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [CNT_W-1:0]  res_count,
  output logic [CNT_W-1:0]  freq_count,
  output logic [TEMP_W-1:0] temp_cdeg,
  output logic              done
);

  localparam int DIFF_W = CNT_W + 2;
  localparam int PROD_W = DIFF_W + KQ_W + 1;
  localparam logic signed [DIFF_W-1:0] F_CAL  = DIFF_W'(F_CAL_COUNT);
  localparam logic signed [PROD_W-1:0] K_EXT  = PROD_W'(K_Q);
  localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(1) <<< (FRAC - 1);
  localparam logic signed [PROD_W-1:0] T_BASE = PROD_W'(T_CAL_CDEG);

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] diff_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic [TEMP_W-1:0]        temp_d;
  logic [CNT_W-1:0]         freq_q;
  logic [TEMP_W-1:0]        temp_q;
  logic                     done_q;

  always_comb begin
    diff     = F_CAL - $signed({2'b00, res_count});
    diff_ext = PROD_W'(diff);
    prod     = diff_ext * K_EXT;
    scaled   = (prod + HALF) >>> FRAC;
    temp_d   = TEMP_W'(scaled + T_BASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
      temp_q <= '0;
    end else if (res_valid) begin
      freq_q <= res_count;
      temp_q <= temp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= res_valid;
    end
  end

  assign freq_count = freq_q;
  assign temp_cdeg  = temp_q;
  assign done       = done_q;

endmodule

// File: rtl/ro_temp_conv.sv
// Top: duty-cycled oscillator edge count converted to centi-degrees.
module ro_temp_conv #(
  parameter int REST_CYCLES = 2750,
  parameter int GATE_CYCLES = 4000,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12,
  parameter int TEMP_W      = 16,
  parameter int F_CAL_COUNT = 999,
  parameter int T_CAL_CDEG  = 2500,
  parameter int KQ_W        = 16,
  parameter int K_Q         = 12367,
  parameter int FRAC        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ro_in,
  output logic              ro_en,
  output logic [CNT_W-1:0]  freq_count,
  output logic [TEMP_W-1:0] temp_cdeg,
  output logic              done,
  output logic              overflow
);

  logic             rise;
  logic             gate_open;
  logic             win_close;
  logic             res_valid;
  logic [CNT_W-1:0] res_count;

  ro_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .ro_in (ro_in),
    .rise  (rise)
  );

  ro_gate_ctrl #(
    .REST_CYCLES (REST_CYCLES),
    .GATE_CYCLES (GATE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .gate_open (gate_open),
    .win_close (win_close)
  );

  ro_edge_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_open (gate_open),
    .rise      (rise),
    .win_close (win_close),
    .res_valid (res_valid),
    .res_count (res_count),
    .overflow  (overflow)
  );

  ro_temp_calc #(
    .CNT_W       (CNT_W),
    .TEMP_W      (TEMP_W),
    .F_CAL_COUNT (F_CAL_COUNT),
    .T_CAL_CDEG  (T_CAL_CDEG),
    .KQ_W        (KQ_W),
    .K_Q         (K_Q),
    .FRAC        (FRAC)
  ) u_calc (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_count  (res_count),
    .freq_count (freq_count),
    .temp_cdeg  (temp_cdeg),
    .done       (done)
  );

  assign ro_en = gate_open;

endmodule

// File: rtl/ro_temp_conv_chk.sv
module ro_temp_conv_chk #(
  parameter int GATE_CYCLES = 4000,
  parameter int CNT_W       = 12,
  parameter int TEMP_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              ro_en,
  input logic [CNT_W-1:0]  freq_count,
  input logic [TEMP_W-1:0] temp_cdeg,
  input logic              done,
  input logic              overflow
);

  localparam int RUN_W = $clog2(GATE_CYCLES + 2);
  localparam logic [RUN_W-1:0] GATE_LEN = RUN_W'(GATE_CYCLES);

  // Number of consecutive earlier cycles with ro_en high
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (ro_en) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  AST_WIN_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ro_en |-> (run_q < GATE_LEN)); // R1

  AST_WIN_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ro_en) && $past(enable)) |-> (run_q == GATE_LEN)); // R1

  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(freq_count)); // R3

  AST_HOLD_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(temp_cdeg)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_DONE_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ro_en, 2) && !$past(ro_en))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R6

  AST_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ro_en); // R7

endmodule

bind ro_temp_conv ro_temp_conv_chk #(
  .GATE_CYCLES (GATE_CYCLES),
  .CNT_W       (CNT_W),
  .TEMP_W      (TEMP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .ro_en      (ro_en),
  .freq_count (freq_count),
  .temp_cdeg  (temp_cdeg),
  .done       (done),
  .overflow   (overflow)
);

// File: tb/test_ro_temp_conv.sv
module test_ro_temp_conv;

  localparam int REST   = 10;
  localparam int GATE   = 40;
  localparam int CNT_W  = 4;
  localparam int TEMP_W = 16;
  localparam int F_CAL  = 10;
  localparam int T_CAL  = 2500;
  localparam int K_Q    = 300;
  localparam int FRAC   = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic ro = 1'b0;

  logic              ro_en;
  logic [CNT_W-1:0]  freq_count;
  logic [TEMP_W-1:0] temp_cdeg;
  logic              done;
  logic              overflow;

  always #10 clk = ~clk;

  ro_temp_conv #(
    .REST_CYCLES (REST),
    .GATE_CYCLES (GATE),
    .SYNC_STAGES (2),
    .CNT_W       (CNT_W),
    .TEMP_W      (TEMP_W),
    .F_CAL_COUNT (F_CAL),
    .T_CAL_CDEG  (T_CAL),
    .KQ_W        (16),
    .K_Q         (K_Q),
    .FRAC        (FRAC)
  ) i_ro_temp_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .ro_in      (ro),
    .ro_en      (ro_en),
    .freq_count (freq_count),
    .temp_cdeg  (temp_cdeg),
    .done       (done),
    .overflow   (overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference model state
  int m_state = 0;  // 0 off, 1 rest, 2 window
  int m_timer = 0;
  int m_cnt = 0;
  int m_pend = 0;
  int m_pend_cnt = 0;
  int m_freq = 0;
  int m_temp = 0;
  int m_done = 0;
  int m_ovf = 0;
  bit roq[$] = '{1'b0, 1'b0, 1'b0};
  bit m_rise;
  bit m_gate;
  bit m_close;

  // Oscillator model
  int per = 4;
  int ph = 0;

  function automatic int ref_temp(int n);
    int p;
    p = (F_CAL - n) * K_Q;
    return T_CAL + ((p + (1 << (FRAC - 1))) >>> FRAC);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!ro_en) begin
      ph = 0;
      ro <= 1'b0;
    end else begin
      ph = (ph + 1) % per;
      ro <= (ph < per / 2);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_timer = 0; m_cnt = 0; m_pend = 0; m_pend_cnt = 0;
      m_freq = 0; m_temp = 0; m_done = 0; m_ovf = 0;
      roq = '{1'b0, 1'b0, 1'b0};
    end else begin
      m_rise  = roq[1] && !roq[2];
      m_gate  = (m_state == 2);
      m_close = m_gate && enable && (m_timer == GATE - 1);
      if (m_pend != 0) begin
        m_freq = m_pend_cnt;
        m_temp = ref_temp(m_pend_cnt);
        m_done = 1;
      end else begin
        m_done = 0;
      end
      if (!m_gate) m_cnt = 0;
      else if (m_rise) begin
        if (m_cnt == CMAX) m_ovf = 1;
        else m_cnt++;
      end
      m_pend = m_close ? 1 : 0;
      if (m_close) m_pend_cnt = m_cnt;
      case (m_state)
        0: if (enable) begin m_state = 1; m_timer = 0; end
        1: begin
          if (!enable) begin m_state = 0; m_timer = 0; end
          else if (m_timer == REST - 1) begin m_state = 2; m_timer = 0; end
          else m_timer++;
        end
        default: begin
          if (!enable) begin m_state = 0; m_timer = 0; end
          else if (m_close) begin m_state = 1; m_timer = 0; end
          else m_timer++;
        end
      endcase
      roq.push_front(ro);
      void'(roq.pop_back());
    end
  end

  // Per-cycle comparison against the model, away from the clock edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk(ro_en == (m_state == 2), enable ? "R1 ro_en" : "R7 ro_en", int'(ro_en), int'(m_state == 2));
      chk(done == (m_done != 0), "R4 done", int'(done), m_done);
      chk(int'(freq_count) == m_freq, (m_done != 0) ? "R2 freq_count" : "R3 freq_count held",
          int'(freq_count), m_freq);
      chk(int'($signed(temp_cdeg)) == m_temp, (m_done != 0) ? "R5 temp_cdeg" : "R3 temp_cdeg held",
          int'($signed(temp_cdeg)), m_temp);
      chk(overflow == (m_ovf != 0), "R6 overflow", int'(overflow), m_ovf);
    end
  end

  task automatic check_reset_state();
    @(posedge clk);
    #6;
    chk(ro_en == 1'b0, "R8 ro_en after reset", int'(ro_en), 0);
    chk(done == 1'b0, "R8 done after reset", int'(done), 0);
    chk(freq_count == '0, "R8 freq_count after reset", int'(freq_count), 0);
    chk(temp_cdeg == '0, "R8 temp_cdeg after reset", int'(temp_cdeg), 0);
    chk(overflow == 1'b0, "R8 overflow after reset", int'(overflow), 0);
  endtask

  task automatic run_period(int p, int cycles);
    @(negedge clk);
    per = p;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : stim
    int seen_done;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();
    @(negedge clk);
    enable = 1'b1;
    run_period(4, 160);
    run_period(5, 150);
    run_period(3, 150);
    run_period(8, 150);
    // Cut a window short: no done, results kept (R7)
    while (!ro_en) @(negedge clk);
    repeat (10) @(negedge clk);
    held = int'(freq_count);
    enable = 1'b0;
    seen_done = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) seen_done++;
    end
    chk(seen_done == 0, "R7 no done after abort", seen_done, 0);
    chk(int'(freq_count) == held, "R7 freq_count kept after abort", int'(freq_count), held);
    chk(ro_en == 1'b0, "R7 oscillator stopped", int'(ro_en), 0);
    enable = 1'b1;
    run_period(6, 150);
    run_period(2, 150);
    chk(overflow == 1'b1, "R6 overflow after fast oscillator", int'(overflow), 1);
    // Reset in the middle of a run (R8)
    @(negedge clk);
    rst_n = 1'b0;
    enable = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();
    @(negedge clk);
    enable = 1'b1;
    run_period(4, 120);
    finish_run();
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule